// File: doc/BRIEF.md
# Asynchronous Disk Write Serializer

This block turns bytes supplied by a host into a bit-cell write waveform for a fast drive, without help from a table-driven sequencer. A bit-cell clock enable paces it. When the block is armed, it waits half a bit cell. It then copies the host data register into a shift latch once per byte period. Every bit-cell boundary it sends the latch's top bit out. A 1 bit inverts the write line and a 0 bit leaves the line as it is. The latch then shifts left.

The host keeps the stream going by polling a handshake byte. A ready bit tells the host that the data register can take the next byte. A sticky underrun bit tells the host that a byte period began with no fresh data. In that case the previous byte is sent again. Leaving the write condition returns the serializer to idle and clears the underrun record.

Top module: `async_wr_serializer`

## Requirements
- R1: After reset, `wr_line` is 0 and `hs_byte` reads 0x9F: bits 4..0 are 1, bit 5 is 0, bit 7 (ready) is 1 and bit 6 (flowing) is 0.
- R2: The serializer runs only while `write_sel`, `async_mode` and at least one of `drive_35` or `aux_en` are all 1. In any other case no activity starts, whatever the number of bit-cell clocks.
- R3: After the serializer starts running, the first START_DLY (4) bit-cell clocks produce no output and no activation. The next bit-cell clock activates the serializer, loads the latch and emits the first bit.
- R4: While active, the data register is copied into the latch every BIT_CLKS*8 (64) bit-cell clocks, starting at activation. Each load clears the data-full flag.
- R5: A load that finds data-full clear sets an underrun flag. The latch then gets the old register contents again. The underrun flag stays set for as long as the serializer keeps running, even if new data is written.
- R6: While active, every BIT_CLKS (8) bit-cell clocks the latch's bit 7 is emitted: a 1 inverts `wr_line` and a 0 leaves it unchanged. The latch then shifts left with a 0 inserted, so bits go out MSB first.
- R7: `hs_byte` bit 7 is 0 exactly when the serializer is active and data-full is set.
- R8: `hs_byte` bit 6 is 1 exactly when the serializer is active and no underrun has occurred.
- R9: When the run condition drops, the counter, the active flag, the underrun flag and `wr_line` all clear by the next clock.
- R10: A `host_wr` strobe stores `host_data` and sets data-full. If the strobe comes in the same cycle as a load, the latch takes the previous register value and the new byte stays pending, with data-full still set.
- R11: Clock cycles without `bit_tick` change neither `wr_line` nor the handshake state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per bit-cell clock |
| write_sel | input | 1 | Controller is in its write state |
| async_mode | input | 1 | Asynchronous write mode selected |
| drive_35 | input | 1 | High-speed drive type selected |
| aux_en | input | 1 | Secondary device enable asserted |
| host_wr | input | 1 | Host strobe that writes the data register |
| host_data | input | 8 | Byte written by the host |
| wr_line | output | 1 | Write waveform to the drive |
| hs_byte | output | 8 | Handshake byte for host polling |

## Verification
The bench builds the block with its default parameters: a 4-clock start delay and 8 clocks per bit, which gives a 64-clock byte period. With these values two full byte periods, including the boundary where a refill, an underrun or a coincident host strobe decides the latch contents, fit in a few hundred cycles. The bench spaces `bit_tick` one idle cycle apart, so the enable gating is exercised on every step. Each scenario computes the expected waveform bit by bit from the bytes it wrote.

// File: rtl/aws_pkg.sv
// Shared constants and helpers for the asynchronous write serializer.
// Assumes byte-wide host data; the handshake layout is fixed to 8 bits.
package aws_pkg;
    localparam int DATA_W = 8;
    localparam int HS_W   = 8;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [HS_W-1:0]   hs_t;

    // Assemble the handshake byte from serializer state.
    function automatic hs_t pack_handshake(input logic active,
                                           input logic full,
                                           input logic underrun);
        hs_t v;
        v      = '0;
        v[4:0] = 5'b11111;
        v[5]   = 1'b0;
        v[6]   = active & ~underrun;
        v[7]   = ~(active & full);
        return v;
    endfunction
endpackage

// File: rtl/aws_cell_timer.sv
// Bit-cell counter for the asynchronous write serializer.
// Counts START_DLY enabled clocks after run rises, then activates and runs
// modulo one byte period. Emits load strobes at byte boundaries and shift
// strobes at bit boundaries. Assumes run is stable between bit_tick pulses.
module aws_cell_timer #(
    parameter int BIT_CLKS  = 8,
    parameter int START_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic active,
    output logic load_now,
    output logic shift_now
);
    localparam int BYTE_CLKS = BIT_CLKS * aws_pkg::DATA_W;
    localparam int CNT_MAX   = (BYTE_CLKS > START_DLY + 1) ? BYTE_CLKS : START_DLY + 1;
    localparam int CNT_W     = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             at_start;
    logic             step_active;
    logic [CNT_W-1:0] cnt_eff;
    logic             step;

    // Decode which position this enabled clock represents.
    always_comb begin
        at_start    = !active_q && (cnt_q == CNT_W'(START_DLY));
        step_active = active_q || at_start;
        cnt_eff     = active_q ? cnt_q : '0;
        step        = run && tick;
        load_now    = step && step_active && (cnt_eff == '0);
        shift_now   = step && step_active && ((cnt_eff % CNT_W'(BIT_CLKS)) == '0);
    end

    // Advance the counter and track activation.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (tick) begin
            if (step_active) begin
                active_q <= 1'b1;
                cnt_q    <= (cnt_eff == CNT_W'(BYTE_CLKS - 1)) ? '0 : cnt_eff + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active = active_q;
endmodule

// File: rtl/aws_shift_unit.sv
// Data register, shift latch and write-line toggle for the serializer.
// The host may write the data register at any time. A load copies the value
// the register held before the current edge, so a coincident write stays
// pending. Assumes every load_now also comes with shift_now.
module aws_shift_unit (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          host_wr,
    input  aws_pkg::data_t host_data,
    input  logic          load_now,
    input  logic          shift_now,
    output logic          wr_line,
    output logic          full,
    output logic          underrun
);
    localparam int MSB = aws_pkg::DATA_W - 1;

    aws_pkg::data_t data_q;
    aws_pkg::data_t latch_q;
    aws_pkg::data_t latch_src;
    logic           full_q;
    logic           under_q;
    logic           line_q;

    // Select the latch contents seen by this cycle's shift.
    always_comb begin
        latch_src = load_now ? data_q : latch_q;
    end

    // Host data register and its full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (host_wr) begin
                data_q <= host_data;
            end
            if (host_wr) begin
                full_q <= 1'b1;
            end else if (load_now) begin
                full_q <= 1'b0;
            end
        end
    end

    // Sticky underrun record, cleared when the run condition drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            under_q <= 1'b0;
        end else if (load_now && !full_q) begin
            under_q <= 1'b1;
        end
    end

    // Shift latch: load, then shift left with zero fill.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            latch_q <= '0;
        end else if (shift_now) begin
            latch_q <= {latch_src[MSB-1:0], 1'b0};
        end else begin
            latch_q <= latch_src;
        end
    end

    // Write line inverts on each emitted 1 bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            line_q <= 1'b0;
        end else if (shift_now && latch_src[MSB]) begin
            line_q <= ~line_q;
        end
    end

    assign wr_line  = line_q;
    assign full     = full_q;
    assign underrun = under_q;
endmodule

// File: rtl/aws_hs_format.sv
// Handshake byte formatter: purely combinational view of serializer state.
module aws_hs_format (
    input  logic         active,
    input  logic         full,
    input  logic         underrun,
    output aws_pkg::hs_t hs_byte
);
    // Pack the polling byte.
    always_comb begin
        hs_byte = aws_pkg::pack_handshake(active, full, underrun);
    end
endmodule

// File: rtl/async_wr_serializer.sv
// Asynchronous write serializer top. Decodes the run condition from the
// mode inputs, paces the bit cells, shifts host bytes out as line
// inversions and reports flow-control state in a handshake byte.
// Assumes bit_tick is a single-cycle enable derived from the bit-cell clock.
module async_wr_serializer #(
    parameter int BIT_CLKS  = 8,
    parameter int START_DLY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       write_sel,
    input  logic       async_mode,
    input  logic       drive_35,
    input  logic       aux_en,
    input  logic       host_wr,
    input  logic [7:0] host_data,
    output logic       wr_line,
    output logic [7:0] hs_byte
);
    logic run;
    logic active;
    logic load_now;
    logic shift_now;
    logic full;
    logic underrun;

    // Run only in write state, async mode, on a qualifying device.
    always_comb begin
        run = write_sel && async_mode && (drive_35 || aux_en);
    end

    aws_cell_timer #(
        .BIT_CLKS (BIT_CLKS),
        .START_DLY(START_DLY)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (bit_tick),
        .active   (active),
        .load_now (load_now),
        .shift_now(shift_now)
    );

    aws_shift_unit u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .host_wr  (host_wr),
        .host_data(host_data),
        .load_now (load_now),
        .shift_now(shift_now),
        .wr_line  (wr_line),
        .full     (full),
        .underrun (underrun)
    );

    aws_hs_format u_hs (
        .active  (active),
        .full    (full),
        .underrun(underrun),
        .hs_byte (hs_byte)
    );
endmodule

// File: rtl/aws_checker.sv
// Port-level temporal checks for the serializer, bound to the top module.
module aws_checker #(
    parameter int START_DLY = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       write_sel,
    input logic       async_mode,
    input logic       drive_35,
    input logic       aux_en,
    input logic       host_wr,
    input logic       wr_line,
    input logic [7:0] hs_byte
);
    logic run_c;

    // Independent decode of the run condition from the mode ports.
    always_comb begin
        run_c = write_sel && async_mode && (drive_35 || aux_en);
    end

    assert_line_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_c |=> !wr_line);

    assert_line_needs_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        run_c && !bit_tick |=> $stable(wr_line));

    assert_underrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_c && hs_byte[6] && !bit_tick |=> hs_byte[6]);

    assert_full_blocks_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && hs_byte[6] && run_c |=> !hs_byte[7]);

    assert_start_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (START_DLY > 0) && $rose(run_c) |=> !hs_byte[6]);
endmodule

bind async_wr_serializer aws_checker #(.START_DLY(START_DLY)) u_aws_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .write_sel (write_sel),
    .async_mode(async_mode),
    .drive_35  (drive_35),
    .aux_en    (aux_en),
    .host_wr   (host_wr),
    .wr_line   (wr_line),
    .hs_byte   (hs_byte)
);

// File: tb/async_wr_serializer_bench.sv
module async_wr_serializer_bench;
    localparam int BIT_CLKS  = 8;
    localparam int START_DLY = 4;
    localparam int BYTE_CLKS = BIT_CLKS * 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       write_sel = 1'b0;
    logic       async_mode = 1'b0;
    logic       drive_35 = 1'b0;
    logic       aux_en = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       wr_line;
    logic [7:0] hs_byte;

    int  checks = 0;
    int  fails = 0;
    bit  done = 0;
    logic exp_line;

    always #5 clk = ~clk;

    async_wr_serializer #(.BIT_CLKS(BIT_CLKS), .START_DLY(START_DLY)) u_async_wr_serializer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .write_sel(write_sel),
        .async_mode(async_mode), .drive_35(drive_35), .aux_en(aux_en),
        .host_wr(host_wr), .host_data(host_data), .wr_line(wr_line), .hs_byte(hs_byte)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic step_wr(input logic [7:0] d);
        @(negedge clk) begin bit_tick = 1'b1; host_wr = 1'b1; host_data = d; end
        @(negedge clk) begin bit_tick = 1'b0; host_wr = 1'b0; end
    endtask

    task automatic hwrite(input logic [7:0] d);
        @(negedge clk) begin host_wr = 1'b1; host_data = d; end
        @(negedge clk) host_wr = 1'b0;
    endtask

    // One active step at position t with byte cur in the latch.
    task automatic astep(input int t, input logic [7:0] cur, input bit with_wr, input logic [7:0] d);
        if (with_wr) step_wr(d); else step();
        if ((t % BIT_CLKS) == 0 && cur[7 - ((t / BIT_CLKS) % 8)]) exp_line = ~exp_line;
    endtask

    task automatic leave();
        @(negedge clk) write_sel = 1'b0;
        @(negedge clk);
        exp_line = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk) begin write_sel = 1'b1; async_mode = 1'b1; drive_35 = 1'b1; end
        for (int i = 0; i < START_DLY; i++) step();
    endtask

    task automatic t_reset();
        chk("R1 line", {7'd0, wr_line}, 8'h00);
        chk("R1 hs", hs_byte, 8'h9F);
    endtask

    task automatic t_gating();
        hwrite(8'hFF);
        @(negedge clk) begin write_sel = 1'b1; async_mode = 1'b0; drive_35 = 1'b1; end
        for (int i = 0; i < 12; i++) step();
        chk("R2 no async line", {7'd0, wr_line}, 8'h00);
        chk("R2 no async hs", hs_byte, 8'h9F);
        @(negedge clk) begin async_mode = 1'b1; drive_35 = 1'b0; aux_en = 1'b0; end
        for (int i = 0; i < 12; i++) step();
        chk("R2 no device hs", hs_byte, 8'h9F);
        @(negedge clk) aux_en = 1'b1;
        for (int i = 0; i < START_DLY + 1; i++) step();
        chk("R2 aux enable runs hs", hs_byte, 8'hDF);
        chk("R2 aux enable runs line", {7'd0, wr_line}, 8'h01);
        @(negedge clk) aux_en = 1'b0;
        leave();
    endtask

    task automatic t_start();
        hwrite(8'hFF);
        chk("R10 inactive full keeps ready", hs_byte, 8'h9F);
        arm();
        chk("R3 delay line", {7'd0, wr_line}, 8'h00);
        chk("R3 delay hs", hs_byte, 8'h9F);
        step();
        chk("R3 activation line", {7'd0, wr_line}, 8'h01);
        chk("R4 load clears full", hs_byte, 8'hDF);
        leave();
        chk("R9 leave line", {7'd0, wr_line}, 8'h00);
        chk("R9 leave hs", hs_byte, 8'h9F);
    endtask

    task automatic t_serial();
        hwrite(8'hA5);
        arm();
        exp_line = 1'b0;
        for (int t = 0; t < 2 * BYTE_CLKS; t++) begin
            astep(t, (t < BYTE_CLKS) ? 8'hA5 : 8'h3C, 1'b0, 8'h00);
            if (t == 20) begin
                hwrite(8'h3C);
                chk("R7 full while active", hs_byte, 8'h5F);
            end
            if ((t % BIT_CLKS) == 0) chk("R6 bit line", {7'd0, wr_line}, {7'd0, exp_line});
            if (t == BYTE_CLKS) chk("R8 refill on time", hs_byte, 8'hDF);
        end
        leave();
    endtask

    task automatic t_underrun();
        hwrite(8'h81);
        arm();
        exp_line = 1'b0;
        for (int t = 0; t <= BYTE_CLKS; t++) astep(t, 8'h81, 1'b0, 8'h00);
        chk("R5 underrun flagged", hs_byte, 8'h9F);
        chk("R5 old byte resent", {7'd0, wr_line}, {7'd0, exp_line});
        hwrite(8'h55);
        chk("R5 sticky after refill", hs_byte, 8'h1F);
        for (int i = 0; i < 10; i++) step();
        chk("R11 ticks keep underrun", hs_byte, 8'h1F);
        leave();
        chk("R9 underrun cleared", hs_byte, 8'h9F);
        arm();
        step();
        chk("R9 restart clean", hs_byte, 8'hDF);
        leave();
    endtask

    task automatic t_coincide();
        hwrite(8'h80);
        arm();
        exp_line = 1'b0;
        for (int t = 0; t < BYTE_CLKS; t++) begin
            astep(t, 8'h80, 1'b0, 8'h00);
            if (t == 10) hwrite(8'h80);
        end
        astep(BYTE_CLKS, 8'h80, 1'b1, 8'h01);
        chk("R10 coincident keeps old byte", {7'd0, wr_line}, {7'd0, exp_line});
        chk("R10 coincident stays pending", hs_byte, 8'h5F);
        for (int t = BYTE_CLKS + 1; t <= 2 * BYTE_CLKS + 7 * BIT_CLKS; t++)
            astep(t, (t < 2 * BYTE_CLKS) ? 8'h80 : 8'h01, 1'b0, 8'h00);
        chk("R10 pending byte sent", {7'd0, wr_line}, {7'd0, exp_line});
        chk("R4 pending byte loaded", hs_byte, 8'hDF);
        leave();
    endtask

    task automatic t_notick();
        hwrite(8'hC3);
        arm();
        step();
        for (int i = 0; i < 30; i++) @(negedge clk);
        chk("R11 idle line", {7'd0, wr_line}, 8'h01);
        chk("R11 idle hs", hs_byte, 8'hDF);
        leave();
    endtask

    initial begin
        exp_line = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gating();
        t_start();
        t_serial();
        t_underrun();
        t_coincide();
        t_notick();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule